// File: doc/BRIEF.md
# Tail-Biting Rate-1/2 Convolutional Encoder

This block encodes one framed block of payload bits at a time with a rate-1/2 convolutional code of constraint length 7. The code uses the octal generators 171 and 133. The code runs in tail-biting mode. Before the first coded pair leaves, the encoder memory is loaded with the final six bits of the same block. The encoder therefore finishes each block in the state it started from, and no zero flush bits are added.

Payload bits enter one per cycle over a valid/ready handshake, marked with start-of-block and end-of-block flags. The whole block is stored first. The encoder then emits one coded pair per cycle with matching block markers, and the downstream side can stall it at any time. A block shorter than the six-bit encoder memory cannot be encoded in this mode. Such a block is discarded and flagged.

Top module: `tbcc_encoder`

## Requirements
- R1: A block of K accepted bits yields exactly K output pairs, 2K coded bits in total. outFirst is high only on the pair of bit 0 and outLast only on the pair of bit K-1.
- R2: For input bit i, build a 7-bit tap vector whose bit 6 is the current bit and whose bit 6-j is the bit j positions earlier. outPair[1] is the parity of that vector ANDed with octal 171. outPair[0] is the parity with octal 133. outPair[1] is the first bit in serial order.
- R3: Before bit 0 is encoded, the memory holds the block's last six bits. Bit K-1 sits in the position one earlier than the current bit, and bit K-6 sits in the oldest position.
- R4: After the pair of bit K-1 is accepted, the encoder memory equals the state it held before bit 0. So the pairs near the end of the block wrap around to bits at the block's start.
- R5: No pair is offered while a block is being loaded, and inReady is low while pairs are being emitted.
- R6: A block with fewer than 6 bits raises errShort for one cycle in the cycle after its last bit is accepted. It produces no output, and the block then returns to accepting input.
- R7: While outValid is high and outReady is low, outPair, outFirst, outLast and outValid hold their values, and no bit is lost.
- R8: A bit with inFirst high starts a new block and discards any partial block stored before it.
- R9: Blocks up to MAX_BITS bits (default 3456, enough for a 3354-bit payload) are encoded in full.
- R10: After reset, inReady is high, and outValid and errShort are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inBit | input | 1 | Payload bit |
| inValid | input | 1 | Payload bit is valid |
| inFirst | input | 1 | Bit is the first of a block |
| inLast | input | 1 | Bit is the last of a block |
| inReady | output | 1 | Block accepts a payload bit |
| outPair | output | 2 | Coded pair: [1] from generator 171, [0] from generator 133 |
| outValid | output | 1 | Pair is valid |
| outFirst | output | 1 | Pair belongs to bit 0 of the block |
| outLast | output | 1 | Pair belongs to the last bit of the block |
| outReady | input | 1 | Downstream takes the pair |
| errShort | output | 1 | One-cycle pulse: block shorter than 6 bits was discarded |

## Verification
The encoder is driven with several input patterns. An isolated single one inside zeros exposes every generator tap separately. An all-ones block checks the parity of full tap sets. Pseudo-random blocks at the 6-bit minimum, at mid sizes and at MAX_BITS separate a correct tail-biting wrap, shown in the first and last pairs, from a zero-started encoder. Stalled output under a repeating ready pattern shows whether pairs are held or dropped. A 3-bit block and a partial block cut off by a new start-of-block check the reject path and the restart path.

// File: rtl/tbcc_pkg.sv
package tbcc_pkg;
  localparam int MEM_LEN = 6;
  localparam logic [MEM_LEN:0] GEN_A = 7'o171;
  localparam logic [MEM_LEN:0] GEN_B = 7'o133;

  typedef enum logic [1:0] {ST_LOAD, ST_CHECK, ST_ENC} tbcc_state_t;

  typedef struct packed {
    logic wrBit;
    logic restart;
    logic clear;
    logic startEnc;
    logic advance;
  } tbcc_strobe_t;
endpackage

// File: rtl/tbcc_datapath.sv
module tbcc_datapath
  import tbcc_pkg::*;
#(
  parameter int MAX_BITS = 3456
) (
  input  logic         clk,
  input  logic         rstN,
  input  tbcc_strobe_t stb,
  input  logic         inBit,
  output logic         lenShort,
  output logic         atFirst,
  output logic         atLast,
  output logic [1:0]   pair
);
  localparam int AW = $clog2(MAX_BITS + 1);
  localparam int IW = $clog2(MAX_BITS);

  logic [MAX_BITS-1:0] bufBits;
  logic [AW-1:0]       wrPtr;
  logic [AW-1:0]       rdIdx;
  logic [AW-1:0]       blkLen;
  logic [MEM_LEN-1:0]  sr;
  logic [MEM_LEN-1:0]  startSt;
  logic                curBit;
  logic [MEM_LEN:0]    tapVec;
  logic                roomLeft;

  assign roomLeft = wrPtr < AW'(MAX_BITS);

  always_ff @(posedge clk) begin
    if (stb.wrBit) begin
      if (stb.restart) bufBits[0] <= inBit;
      else if (roomLeft) bufBits[wrPtr[IW-1:0]] <= inBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdIdx   <= '0;
      blkLen  <= '0;
      sr      <= '0;
      startSt <= '0;
    end else begin
      if (stb.clear) begin
        wrPtr <= '0;
      end else if (stb.wrBit) begin
        if (stb.restart) begin
          wrPtr <= AW'(1);
          sr    <= {inBit, sr[MEM_LEN-1:1]};
        end else if (roomLeft) begin
          wrPtr <= wrPtr + AW'(1);
          sr    <= {inBit, sr[MEM_LEN-1:1]};
        end
      end
      if (stb.startEnc) begin
        rdIdx   <= '0;
        blkLen  <= wrPtr;
        startSt <= sr;
      end else if (stb.advance) begin
        rdIdx <= rdIdx + AW'(1);
        sr    <= {curBit, sr[MEM_LEN-1:1]};
      end
    end
  end

  assign curBit   = bufBits[rdIdx[IW-1:0]];
  assign tapVec   = {curBit, sr};
  assign pair[1]  = ^(tapVec & GEN_A);
  assign pair[0]  = ^(tapVec & GEN_B);
  assign lenShort = wrPtr < AW'(MEM_LEN);
  assign atFirst  = rdIdx == '0;
  assign atLast   = rdIdx == (blkLen - AW'(1));

  // R4
  tail_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && atLast) |=> (sr == startSt));
endmodule

// File: rtl/tbcc_ctrl.sv
module tbcc_ctrl
  import tbcc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inFirst,
  input  logic         inLast,
  input  logic         outReady,
  input  logic         lenShort,
  input  logic         atLast,
  output tbcc_strobe_t stb,
  output logic         inReady,
  output logic         outValid,
  output logic         errShort
);
  tbcc_state_t state, stateNext;
  logic accept;

  assign inReady  = state == ST_LOAD;
  assign outValid = state == ST_ENC;
  assign accept   = inValid && inReady;
  assign errShort = (state == ST_CHECK) && lenShort;

  always_comb begin
    stb          = '0;
    stb.wrBit    = accept;
    stb.restart  = accept && inFirst;
    stb.startEnc = (state == ST_CHECK) && !lenShort;
    stb.advance  = outValid && outReady;
    stb.clear    = errShort || (stb.advance && atLast);
    stateNext    = state;
    case (state)
      ST_LOAD:  if (accept && inLast) stateNext = ST_CHECK;
      ST_CHECK: stateNext = lenShort ? ST_LOAD : ST_ENC;
      ST_ENC:   if (stb.advance && atLast) stateNext = ST_LOAD;
      default:  stateNext = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOAD;
    else       state <= stateNext;
  end

  // R6
  short_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    errShort |=> (inReady && !outValid));
  // R1
  last_pair_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && atLast) |=> !outValid);
  // R5
  load_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inLast) |=> !outValid);
endmodule

// File: rtl/tbcc_encoder.sv
module tbcc_encoder
  import tbcc_pkg::*;
#(
  parameter int MAX_BITS = 3456
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inBit,
  input  logic       inValid,
  input  logic       inFirst,
  input  logic       inLast,
  output logic       inReady,
  output logic [1:0] outPair,
  output logic       outValid,
  output logic       outFirst,
  output logic       outLast,
  input  logic       outReady,
  output logic       errShort
);
  tbcc_strobe_t stb;
  logic lenShort, atFirst, atLast, encValid;

  tbcc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .inLast(inLast), .outReady(outReady), .lenShort(lenShort),
    .atLast(atLast), .stb(stb), .inReady(inReady), .outValid(encValid),
    .errShort(errShort)
  );

  tbcc_datapath #(.MAX_BITS(MAX_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .inBit(inBit),
    .lenShort(lenShort), .atFirst(atFirst), .atLast(atLast), .pair(outPair)
  );

  assign outValid = encValid;
  assign outFirst = encValid && atFirst;
  assign outLast  = encValid && atLast;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outPair) &&
                                 $stable(outFirst) && $stable(outLast)));
endmodule

// File: tb/tbcc_encoder_tb.sv
module tbcc_encoder_tb_top;
  localparam int MAX = 3456;

  logic clk = 0, rstN = 0;
  logic inBit = 0, inValid = 0, inFirst = 0, inLast = 0, outReady = 1;
  logic inReady, outValid, outFirst, outLast, errShort;
  logic [1:0] outPair;

  int total = 0, bad = 0;
  bit blk [0:MAX-1];
  bit errAtEnd, sawOut;

  always #5 clk = ~clk;

  tbcc_encoder #(.MAX_BITS(MAX)) dut_i (
    .clk(clk), .rstN(rstN), .inBit(inBit), .inValid(inValid),
    .inFirst(inFirst), .inLast(inLast), .inReady(inReady),
    .outPair(outPair), .outValid(outValid), .outFirst(outFirst),
    .outLast(outLast), .outReady(outReady), .errShort(errShort)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit tap(int i, int j, int k);
    return blk[(i - j + k) % k];
  endfunction

  function automatic logic [1:0] refPair(int i, int k);
    logic a, b;
    a = tap(i,0,k) ^ tap(i,1,k) ^ tap(i,2,k) ^ tap(i,3,k) ^ tap(i,6,k);
    b = tap(i,0,k) ^ tap(i,2,k) ^ tap(i,3,k) ^ tap(i,5,k) ^ tap(i,6,k);
    return {a, b};
  endfunction

  task automatic fillRand(int k, int seed);
    int unsigned s;
    s = seed;
    for (int i = 0; i < k; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      blk[i] = s[7];
    end
  endtask

  task automatic sendBits(int k, bit withLast);
    sawOut = 0;
    for (int i = 0; i < k; ) begin
      @(negedge clk);
      if (outValid) sawOut = 1;
      inValid = 1; inBit = blk[i]; inFirst = (i == 0);
      inLast = withLast && (i == k - 1);
      if (inReady) i++;
    end
    @(negedge clk);
    inValid = 0; inFirst = 0; inLast = 0;
    errAtEnd = errShort;
  endtask

  task automatic runBlock(int k, bit stallMode, string name);
    int n, cyc, bR2, bR3, bR4, flagBad, stallBad;
    bit done, stalled, rdy;
    logic [1:0] hold, exp;
    sendBits(k, 1);
    chk(!sawOut, "R5", {name, " output during load"}, sawOut, 0);
    n = 0; cyc = 0; bR2 = 0; bR3 = 0; bR4 = 0; flagBad = 0; stallBad = 0;
    done = 0; stalled = 0; hold = 0;
    while (!done && cyc < 4 * k + 50) begin
      @(negedge clk);
      cyc++;
      if (stalled && (!outValid || outPair != hold)) stallBad++;
      rdy = stallMode ? (cyc % 3 != 0) : 1'b1;
      outReady = rdy;
      if (outValid && inReady) flagBad++;
      if (outValid && rdy) begin
        exp = refPair(n, k);
        if (outPair != exp) begin
          if (n == k - 1) bR4++; else if (n < 6) bR3++; else bR2++;
        end
        if (outFirst != (n == 0) || outLast != (n == k - 1)) flagBad++;
        if (outLast) done = 1;
        n++;
        stalled = 0;
      end else if (outValid) begin
        stalled = 1; hold = outPair;
      end else stalled = 0;
    end
    outReady = 1;
    chk(n == k, "R1", {name, " pair count"}, n, k);
    chk(flagBad == 0, "R1", {name, " markers/ready"}, flagBad, 0);
    chk(bR2 == 0, "R2", {name, " body pairs"}, bR2, 0);
    chk(bR3 == 0, "R3", {name, " preloaded first pairs"}, bR3, 0);
    chk(bR4 == 0, "R4", {name, " wrapped last pair"}, bR4, 0);
    if (stallMode) chk(stallBad == 0, "R7", {name, " held under stall"}, stallBad, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(inReady === 1'b1, "R10", "inReady after reset", inReady, 1);
    chk(outValid === 1'b0, "R10", "outValid after reset", outValid, 0);
    chk(errShort === 1'b0, "R10", "errShort after reset", errShort, 0);
  endtask

  task automatic testImpulse();
    for (int i = 0; i < 12; i++) blk[i] = (i == 4);
    runBlock(12, 0, "impulse R2");
  endtask

  task automatic testOnes();
    for (int i = 0; i < 16; i++) blk[i] = 1;
    runBlock(16, 0, "all-ones");
  endtask

  task automatic testMinLen();
    fillRand(6, 77);
    blk[5] = 1; blk[0] = 0;
    runBlock(6, 0, "minimum six");
  endtask

  task automatic testShort();
    int seenOut, seenErr;
    fillRand(3, 5);
    sendBits(3, 1);
    chk(errAtEnd, "R6", "errShort after 3-bit block", errAtEnd, 1);
    seenOut = 0; seenErr = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (outValid) seenOut++;
      if (errShort) seenErr++;
    end
    chk(seenOut == 0, "R6", "no pairs for short block", seenOut, 0);
    chk(seenErr == 0, "R6", "errShort single cycle", seenErr, 0);
    chk(inReady === 1'b1, "R6", "ready after reject", inReady, 1);
  endtask

  task automatic testRestart();
    for (int i = 0; i < 4; i++) blk[i] = 1;
    sendBits(4, 0);
    fillRand(10, 999);
    runBlock(10, 0, "R8 restart");
  endtask

  task automatic testStall();
    fillRand(40, 1234);
    runBlock(40, 1, "stalled");
  endtask

  task automatic testMax();
    fillRand(MAX, 4242);
    runBlock(MAX, 0, "R9 max length");
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    testReset();
    testImpulse();
    testOnes();
    testMinLen();
    testShort();
    testRestart();
    testStall();
    fillRand(100, 31);
    runBlock(100, 0, "random 100");
    testMax();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule